// File: doc/BRIEF.md
# Voltage ID Slew Sequencer

This block is the digital control core of a step-down regulator. It picks a target voltage code from one of three sources. A suspend input, when high, selects a code decoded from two suspend-select inputs. Otherwise a mode input chooses between the live VID pins and an alternate code that arrives already decoded. The block then moves an internal DAC code toward that target by one LSB, one 25 mV step, on each tick of an external slew clock. This works in both directions. A target change in mid-ramp redirects the ramp toward the new value without returning to zero.

The block also sequences the power rail. Raising the enable input turns the reference on. Once the reference-ready input is seen, the code ramps up from zero. Power-good is asserted only when the ramp has finished and the regulator reports that it is in regulation. Dropping the enable input removes power-good at once and ramps the code down to zero. The block then parks the gates and switches the reference off.

Two conditions override the ramp:
- Supply undervoltage lockout parks the gates in the same cycle and clears the code.
- A fault input sets a latch that parks the gates and holds power-good low until the enable input is toggled.

VID pin changes must stay stable for a programmable number of clocks before they count. This stops skew between bits from starting partial transitions.

Top module: `vid_slew_seq`

## Requirements
- R1: While reset is asserted and after its release with the enable input low, `dac_code_o` is 0, `ref_en_o` is 0, `hs_en_o` is 0, `ls_force_o` is 1 and `pgood_o` is 0.
- R2: The target has two levels of priority. If `susp_i` is 1, the target is `SUSP_BASE + SUSP_STRIDE*susp_sel_i`; with the defaults, select values 0, 1, 2 and 3 give 6, 10, 14 and 18. Else, if `mode_i` is 1, the target is `alt_code_i`. Else it is the filtered VID value.
- R3: The filtered VID value takes a new `vid_i` value only on the clock edge at which that value has been sampled on `STABLE_CYC` consecutive edges. A shorter excursion leaves the target and the output code unchanged.
- R4: While regulating, `dac_code_o` moves exactly one step toward the target on each clock edge that samples `slew_tick_i` high, and holds on other edges. A target change redirects the ramp from the present code.
- R5: A rising enable input sets `ref_en_o` on the next edge. The code stays 0 until `ref_ok_i` is sampled high, and then ramps up from 0.
- R6: `pgood_o` is 1 only while regulating with `dac_code_o` equal to the target, `in_reg_i` high and `en_i` high. It falls in the same cycle that `in_reg_i` or `en_i` falls.
- R7: After the enable input falls, the code steps down by one per tick to 0. On the following edge the block is off: `ref_en_o` is 0, `hs_en_o` is 0 and `ls_force_o` is 1.
- R8: While `uvlo_i` is high, `hs_en_o` is 0, `ls_force_o` is 1 and `pgood_o` is 0 in the same cycle. The code is 0 from the next edge. After release with the enable input high, the block restarts through the reference wait.
- R9: `fault_i` sampled high while enabled latches a fault. From the next edge until the enable input is sampled low, the code is 0, `hs_en_o` is 0, `ls_force_o` is 1 and `pgood_o` is 0.
- R10: `hs_en_o` is high and `ls_force_o` low exactly while the block ramps or regulates, including the ramp down, with no lockout and no fault. The two outputs are always complements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low requests shutdown |
| ref_ok_i | input | 1 | Reference ready (reference undervoltage check passed) |
| uvlo_i | input | 1 | Supply undervoltage lockout active |
| fault_i | input | 1 | Fault event to latch |
| in_reg_i | input | 1 | Output is in regulation |
| slew_tick_i | input | 1 | Slew clock tick, one step per high sample |
| susp_i | input | 1 | Suspend select, highest priority |
| susp_sel_i | input | 2 | Suspend code index |
| mode_i | input | 1 | 1 selects the alternate code, 0 the VID pins |
| vid_i | input | CODE_W | Live VID pins |
| alt_code_i | input | CODE_W | Alternate decoded code |
| dac_code_o | output | CODE_W | Present DAC code |
| ref_en_o | output | 1 | Reference enable |
| hs_en_o | output | 1 | High-side gate enable |
| ls_force_o | output | 1 | Low-side gate forced on |
| pgood_o | output | 1 | Power-good |

## Verification
Some faults lie in the code register or the sequencing state. These appear on `dac_code_o` or the gate outputs at the first tick edge after the error. A missed tick or a double step therefore shows within one slew period. If the VID filter count is wrong, the code starts moving one clock too early or too late. A latch that forgets a fault shows as `hs_en_o` returning high while the enable input is still high. A per-clock comparison of every output against the behavioural model catches each of these on the cycle it first shows.

// File: rtl/vid_slew_pkg.sv
package vid_slew_pkg;
    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_WREF = 3'd1,
        ST_RUN  = 3'd2,
        ST_DOWN = 3'd3,
        ST_LOCK = 3'd4,
        ST_HALT = 3'd5
    } seq_state_e;
endpackage

// File: rtl/vid_stable_filter.sv
module vid_stable_filter #(
    parameter int CODE_W     = 5,
    parameter int STABLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] vid_i,
    output logic [CODE_W-1:0] vid_o
);
    localparam int RUN_W = $clog2(STABLE_CYC + 1);

    typedef struct packed {
        logic [CODE_W-1:0] cand;
        logic [RUN_W-1:0]  run;
        logic [CODE_W-1:0] out;
    } filt_t;

    filt_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (vid_i == r_q.cand) begin
            if (r_q.run < RUN_W'(STABLE_CYC))
                r_d.run = r_q.run + RUN_W'(1);
        end else begin
            r_d.cand = vid_i;
            r_d.run  = RUN_W'(1);
        end
        if (r_d.run == RUN_W'(STABLE_CYC))
            r_d.out = vid_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign vid_o = r_q.out;

    // R3
    filt_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.out != $past(r_q.out)) |-> (r_q.out == $past(vid_i)));
endmodule

// File: rtl/vid_target_select.sv
module vid_target_select #(
    parameter int CODE_W      = 5,
    parameter int SUSP_BASE   = 6,
    parameter int SUSP_STRIDE = 4
) (
    input  logic              susp_i,
    input  logic [1:0]        susp_sel_i,
    input  logic              mode_i,
    input  logic [CODE_W-1:0] vid_filt_i,
    input  logic [CODE_W-1:0] alt_code_i,
    output logic [CODE_W-1:0] target_o
);
    logic [CODE_W-1:0] susp_code;
    logic [CODE_W-1:0] mode_code;

    always_comb begin
        susp_code = CODE_W'(SUSP_BASE + SUSP_STRIDE * int'(susp_sel_i));
        mode_code = mode_i ? alt_code_i : vid_filt_i;
        target_o  = susp_i ? susp_code : mode_code;
    end
endmodule

// File: rtl/code_stepper.sv
module code_stepper #(
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] cur_i,
    input  logic [CODE_W-1:0] goal_i,
    input  logic              tick_i,
    output logic [CODE_W-1:0] nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        if (tick_i) begin
            if (cur_i < goal_i)      nxt_o = cur_i + CODE_W'(1);
            else if (cur_i > goal_i) nxt_o = cur_i - CODE_W'(1);
        end
    end
endmodule

// File: rtl/vid_slew_seq.sv
module vid_slew_seq
    import vid_slew_pkg::*;
#(
    parameter int CODE_W      = 5,
    parameter int STABLE_CYC  = 4,
    parameter int SUSP_BASE   = 6,
    parameter int SUSP_STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              ref_ok_i,
    input  logic              uvlo_i,
    input  logic              fault_i,
    input  logic              in_reg_i,
    input  logic              slew_tick_i,
    input  logic              susp_i,
    input  logic [1:0]        susp_sel_i,
    input  logic              mode_i,
    input  logic [CODE_W-1:0] vid_i,
    input  logic [CODE_W-1:0] alt_code_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              ref_en_o,
    output logic              hs_en_o,
    output logic              ls_force_o,
    output logic              pgood_o
);
    localparam logic [CODE_W-1:0] ZERO = '0;

    typedef struct packed {
        seq_state_e        st;
        logic [CODE_W-1:0] code;
        logic              fault;
    } seq_t;

    seq_t s_q, s_d;

    logic [CODE_W-1:0] vid_filt;
    logic [CODE_W-1:0] target;
    logic [CODE_W-1:0] goal;
    logic [CODE_W-1:0] step_code;
    logic              fault_nx;
    logic              switching;

    vid_stable_filter #(.CODE_W(CODE_W), .STABLE_CYC(STABLE_CYC)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .vid_i (vid_i),
        .vid_o (vid_filt)
    );

    vid_target_select #(.CODE_W(CODE_W), .SUSP_BASE(SUSP_BASE),
                        .SUSP_STRIDE(SUSP_STRIDE)) u_sel (
        .susp_i     (susp_i),
        .susp_sel_i (susp_sel_i),
        .mode_i     (mode_i),
        .vid_filt_i (vid_filt),
        .alt_code_i (alt_code_i),
        .target_o   (target)
    );

    assign goal = (s_q.st == ST_RUN) ? target : ZERO;

    code_stepper #(.CODE_W(CODE_W)) u_step (
        .cur_i  (s_q.code),
        .goal_i (goal),
        .tick_i (slew_tick_i),
        .nxt_o  (step_code)
    );

    always_comb begin
        s_d       = s_q;
        fault_nx  = en_i & (s_q.fault | fault_i);
        s_d.fault = fault_nx;
        if (uvlo_i) begin
            s_d.st   = ST_LOCK;
            s_d.code = ZERO;
        end else if (fault_nx) begin
            s_d.st   = ST_HALT;
            s_d.code = ZERO;
        end else begin
            unique case (s_q.st)
                ST_OFF:  if (en_i) s_d.st = ST_WREF;
                ST_WREF: begin
                    if (!en_i)         s_d.st = ST_OFF;
                    else if (ref_ok_i) s_d.st = ST_RUN;
                end
                ST_RUN: begin
                    if (!en_i) s_d.st   = ST_DOWN;
                    else       s_d.code = step_code;
                end
                ST_DOWN: begin
                    if (en_i)                   s_d.st   = ST_RUN;
                    else if (s_q.code == ZERO)  s_d.st   = ST_OFF;
                    else                        s_d.code = step_code;
                end
                ST_LOCK: s_d.st = en_i ? ST_WREF : ST_OFF;
                ST_HALT: s_d.st = ST_OFF;
                default: s_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= ST_OFF;
            s_q.code  <= ZERO;
            s_q.fault <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign switching  = ((s_q.st == ST_RUN) || (s_q.st == ST_DOWN)) && !uvlo_i && !s_q.fault;
    assign hs_en_o    = switching;
    assign ls_force_o = !switching;
    assign ref_en_o   = (s_q.st == ST_WREF) || (s_q.st == ST_RUN) ||
                        (s_q.st == ST_DOWN) || (s_q.st == ST_HALT);
    assign dac_code_o = s_q.code;
    assign pgood_o    = (s_q.st == ST_RUN) && (s_q.code == target) && in_reg_i &&
                        en_i && !uvlo_i && !s_q.fault;

    // R4
    code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.code != $past(s_q.code) && s_q.code != ZERO) |->
        ($past(slew_tick_i) && (s_q.code == $past(s_q.code) + CODE_W'(1) ||
                                s_q.code == $past(s_q.code) - CODE_W'(1))));

    // R6
    pgood_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgood_o |-> (hs_en_o && in_reg_i && en_i));

    // R8
    uvlo_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |-> (!hs_en_o && ls_force_o && !pgood_o));

    // R7
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en_o |-> (dac_code_o == ZERO && !hs_en_o));

    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fault_i) && $past(en_i) && en_i) |-> (!hs_en_o && !pgood_o));
endmodule

// File: tb/test_vid_slew_seq.sv
`timescale 1ns/1ps
module test_vid_slew_seq;
    localparam int CW  = 5;
    localparam int STB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 0, ref_ok = 0, uvlo = 0, fault = 0, in_reg = 1, tick = 0;
    logic susp = 0, mode = 0;
    logic [1:0] ssel = 0;
    logic [CW-1:0] vid = 0, alt = 0;
    logic [CW-1:0] code;
    logic ref_en, hs_en, ls_force, pgood;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vid_slew_seq i_vid_slew_seq (
        .clk(clk), .rst_n(rst_n), .en_i(en), .ref_ok_i(ref_ok), .uvlo_i(uvlo),
        .fault_i(fault), .in_reg_i(in_reg), .slew_tick_i(tick), .susp_i(susp),
        .susp_sel_i(ssel), .mode_i(mode), .vid_i(vid), .alt_code_i(alt),
        .dac_code_o(code), .ref_en_o(ref_en), .hs_en_o(hs_en),
        .ls_force_o(ls_force), .pgood_o(pgood)
    );

    // behavioural model: phase 0 off, 1 wait ref, 2 regulate, 3 ramp down, 4 lockout, 5 fault
    int m_ph = 0, m_code = 0, m_fault = 0, m_last = 0, m_hold = 0, m_filt = 0;

    function automatic int tgt();
        if (susp) return 6 + 4 * int'(ssel);
        if (mode) return int'(alt);
        return m_filt;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_code = 0; m_fault = 0; m_last = 0; m_hold = 0; m_filt = 0;
        end else begin
            int t, ph, cd, fl;
            t  = tgt();
            ph = m_ph; cd = m_code;
            fl = (en && (m_fault != 0 || fault)) ? 1 : 0;
            if (uvlo) begin ph = 4; cd = 0; end
            else if (fl != 0) begin ph = 5; cd = 0; end
            else if (m_ph == 0) begin if (en) ph = 1; end
            else if (m_ph == 1) begin
                if (!en) ph = 0; else if (ref_ok) ph = 2;
            end else if (m_ph == 2) begin
                if (!en) ph = 3;
                else if (tick && m_code < t) cd = m_code + 1;
                else if (tick && m_code > t) cd = m_code - 1;
            end else if (m_ph == 3) begin
                if (en) ph = 2;
                else if (m_code == 0) ph = 0;
                else if (tick) cd = m_code - 1;
            end else if (m_ph == 4) ph = en ? 1 : 0;
            else ph = 0;
            m_ph = ph; m_code = cd; m_fault = fl;
            if (int'(vid) == m_last) begin
                if (m_hold < STB) m_hold++;
            end else begin
                m_last = int'(vid); m_hold = 1;
            end
            if (m_hold == STB) m_filt = m_last;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int sw;
            sw = ((m_ph == 2 || m_ph == 3) && !uvlo && m_fault == 0) ? 1 : 0;
            chk("R4 code", int'(code), m_code);
            chk("R10 hs_en", int'(hs_en), sw);
            chk("R10 ls_force", int'(ls_force), 1 - sw);
            chk("R5 ref_en", int'(ref_en), (m_ph == 1 || m_ph == 2 || m_ph == 3 || m_ph == 5) ? 1 : 0);
            chk("R6 pgood", int'(pgood),
                (m_ph == 2 && m_code == tgt() && in_reg && en && !uvlo && m_fault == 0) ? 1 : 0);
        end
    end

    // slew tick every fourth clock
    int tcnt = 0;
    always @(posedge clk) begin
        #1;
        tcnt = (tcnt + 1) % 4;
        tick = (tcnt == 0);
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic mid();
        @(negedge clk);
        #0.1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        vid = 10;
        step(3);
        mid();
        chk("R1 code in reset", int'(code), 0);
        chk("R1 ls_force in reset", int'(ls_force), 1);
        rst_n = 1'b1;
        step(10);
        mid();
        chk("R1 ref_en idle", int'(ref_en), 0);
        chk("R1 hs_en idle", int'(hs_en), 0);
        chk("R1 pgood idle", int'(pgood), 0);

        step(1); en = 1;
        step(1); mid();
        chk("R5 ref_en after enable", int'(ref_en), 1);
        step(4); mid();
        chk("R5 code waits for ref", int'(code), 0);
        step(1); ref_ok = 1;
        step(150); mid();
        chk("R4 ramp reaches vid", int'(code), 10);
        chk("R6 pgood after ramp", int'(pgood), 1);
        chk("R10 switching in run", int'(hs_en), 1);

        step(1); vid = 20;
        step(20); vid = 12;
        step(150); mid();
        chk("R4 redirected target", int'(code), 12);

        step(1); vid = 25;
        step(2); vid = 12;
        step(40); mid();
        chk("R3 short excursion ignored", int'(code), 12);

        step(1); mode = 1; alt = 7;
        step(150); mid();
        chk("R2 alternate code", int'(code), 7);
        step(1); susp = 1; ssel = 2;
        step(150); mid();
        chk("R2 suspend code sel 2", int'(code), 14);
        step(1); ssel = 0;
        step(150); mid();
        chk("R2 suspend code sel 0", int'(code), 6);
        step(1); susp = 0; mode = 0;
        step(150); mid();
        chk("R2 back to vid", int'(code), 12);

        step(1); in_reg = 0;
        mid();
        chk("R6 pgood drops with in_reg", int'(pgood), 0);
        step(1); in_reg = 1;

        step(1); en = 0;
        mid();
        chk("R7 pgood drops at once", int'(pgood), 0);
        step(200); mid();
        chk("R7 code zero", int'(code), 0);
        chk("R7 ref off", int'(ref_en), 0);
        chk("R7 ls forced", int'(ls_force), 1);

        step(1); en = 1;
        step(150); mid();
        chk("R5 restart ramp", int'(code), 12);
        step(1); uvlo = 1;
        mid();
        chk("R8 hs off at once", int'(hs_en), 0);
        chk("R8 pgood off at once", int'(pgood), 0);
        step(1); mid();
        chk("R8 code cleared", int'(code), 0);
        step(1); uvlo = 0;
        step(150); mid();
        chk("R8 recovery", int'(code), 12);

        step(1); fault = 1;
        step(1); fault = 0;
        step(20); mid();
        chk("R9 fault code", int'(code), 0);
        chk("R9 fault hs off", int'(hs_en), 0);
        chk("R9 fault pgood", int'(pgood), 0);
        step(1); en = 0;
        step(3); en = 1;
        step(150); mid();
        chk("R9 cleared by toggle", int'(code), 12);
        chk("R10 switching resumed", int'(hs_en), 1);

        step(2);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired: actual running expected finished");
            finish_run();
        end
    end
endmodule